// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block keeps a small table of VLAN entries. Each entry holds a 12-bit VLAN identifier, a 10-bit port membership field and a valid bit. Software never writes the table directly. It goes through two 32-bit registers: a command word and a data word. Software first polls the command word until its busy bit is clear. It then writes the membership into the data word. Finally it writes the command word with an operation code, the busy bit set, and the VID and port the operation needs. The engine carries out the operation over one or more clock cycles and clears the busy bit when it finishes.

Four operations change the table. A load writes an entry. A purge invalidates one entry. A port removal strips one port from every entry. A flush empties the whole table. When a load finds no room, the engine raises a sticky table-full bit in the command word.

A combinational lookup port serves the datapath. It takes a VID and returns whether a valid entry holds that VID, together with that entry's membership.

Top module: `vtab_engine`

## Requirements
- R1: After reset, both registers read zero and a lookup of any VID reports a miss.
- R2: Writing the command word with bit 3 set makes bit 3 read one from the next cycle. Bit 3 then clears after exactly one cycle for every operation except flush.
- R3: Operation code 2 (load), taken from command bits 2:0, stores an entry. The entry takes its VID from command bits 27:16 and its membership from data bits 9:0. It is stored as valid whatever value data bit 11 holds. A lookup of that VID then hits and returns that membership.
- R4: A load whose VID matches a valid entry rewrites that entry's membership and does not use up a free entry.
- R5: A load with no matching entry takes the lowest-index invalid entry. When all 16 entries are valid and none matches, command bit 4 (full) is set and the table is left unchanged. Any later accepted command-word write clears bit 4.
- R6: Operation code 3 (purge) invalidates the entry whose VID equals command bits 27:16, and leaves every other entry as it was.
- R7: Operation code 4 (remove port) clears, in every entry, the membership bit selected by command bits 11:8. A port number of 10 or more changes nothing.
- R8: Operation code 1 (flush) invalidates one entry per cycle. Bit 3 stays set for 16 cycles, and afterwards every lookup misses.
- R9: Writes to either register while bit 3 is set are ignored. They start no operation and leave the register contents unchanged.
- R10: The command word reads back these fields:
  - bit 31: priority enable
  - bits 30:28: priority
  - bits 27:16: VID
  - bits 11:8: port
  - bit 4: full
  - bit 3: busy
  - bits 2:0: operation code

  All other command bits read zero, and bit 4 cannot be written. The data word reads back bits 9:0 and bit 11, with all other data bits zero.
- R11: Operation code 0 and codes 5 to 7 leave the table unchanged and complete in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the command word, 1 the data word |
| reg_wdata | input | 32 | Write data |
| cmd_rdata | output | 32 | Command word readback |
| data_rdata | output | 32 | Data word readback |
| lk_vid | input | 12 | Lookup VID |
| lk_hit | output | 1 | A valid entry holds lk_vid |
| lk_members | output | 10 | Membership of the hitting entry, zero on miss |

## Verification
The table is filled to all 16 entries with distinct VIDs and membership patterns. After every command, the bench sweeps the lookup over every VID the model holds, plus VIDs that were never loaded. This separates a wrong slot choice or a stray write from a correct update. Several load cases are tried: an overwrite of an existing VID, a load into a completely full table, and a load after a purge has freed a slot. Together they show whether an overwrite wrongly consumes a slot and whether freed slots are reused. Port removal is tried with a port inside the membership width and a port beyond it. A flush is run with register writes injected while it is busy, which tells whether those writes are dropped or wrongly accepted.

// File: rtl/vtab_pkg.sv
package vtab_pkg;
    localparam int VID_W   = 12;
    localparam int MEM_W   = 10;
    localparam int PORT_W  = 4;
    localparam int PRIO_W  = 3;
    localparam int REG_W   = 32;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_FLUSH  = 3'd1,
        OP_LOAD   = 3'd2,
        OP_PURGE  = 3'd3,
        OP_STRIP  = 3'd4
    } vop_e;

    typedef struct packed {
        logic             prio_en;
        logic [PRIO_W-1:0] prio;
        logic [VID_W-1:0] vid;
        logic [PORT_W-1:0] port;
        logic [2:0]       op;
    } vcmd_t;

    typedef struct packed {
        logic             valid;
        logic [VID_W-1:0] vid;
        logic [MEM_W-1:0] members;
    } ventry_t;

    // membership mask keeping every bit except the one selected by port
    function automatic logic [MEM_W-1:0] keep_mask(input logic [PORT_W-1:0] port);
        logic [MEM_W-1:0] m;
        for (int j = 0; j < MEM_W; j++)
            m[j] = (32'(port) != j);
        return m;
    endfunction
endpackage

// File: rtl/vtab_regs.sv
module vtab_regs
    import vtab_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             op_done,
    input  logic             set_full,
    output vcmd_t            cmd,
    output logic             busy,
    output logic             full,
    output logic [MEM_W-1:0] dmembers,
    output logic             dvalid
);
    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[15:12], reg_wdata[7:4],
                            reg_wdata[REG_W-1:12] & 20'h0, reg_wdata[10]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd      <= '0;
            busy     <= 1'b0;
            full     <= 1'b0;
            dmembers <= '0;
            dvalid   <= 1'b0;
        end else if (!busy && reg_wr) begin
            if (!reg_sel) begin
                cmd.prio_en <= reg_wdata[31];
                cmd.prio    <= reg_wdata[30:28];
                cmd.vid     <= reg_wdata[27:16];
                cmd.port    <= reg_wdata[11:8];
                cmd.op      <= reg_wdata[2:0];
                busy        <= reg_wdata[3];
                full        <= 1'b0;
            end else begin
                dmembers <= reg_wdata[MEM_W-1:0];
                dvalid   <= reg_wdata[11];
            end
        end else if (busy) begin
            if (set_full) full <= 1'b1;
            if (op_done)  busy <= 1'b0;
        end
    end
endmodule

// File: rtl/vtab_store.sv
module vtab_store
    import vtab_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_go,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [VID_W-1:0] ld_vid,
    input  logic [MEM_W-1:0] ld_members,
    input  logic             inv_go,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic             strip_go,
    input  logic [MEM_W-1:0] strip_keep,
    input  logic [VID_W-1:0] q_vid,
    output logic             q_match,
    output logic [IDX_W-1:0] q_match_idx,
    output logic             q_free,
    output logic [IDX_W-1:0] q_free_idx,
    input  logic [VID_W-1:0] lk_vid,
    output logic             lk_hit,
    output logic [MEM_W-1:0] lk_members
);
    ventry_t tbl [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                tbl[i] <= '0;
            end else if (inv_go && inv_idx == IDX_W'(i)) begin
                tbl[i].valid <= 1'b0;
            end else if (ld_go && ld_idx == IDX_W'(i)) begin
                tbl[i] <= '{valid: 1'b1, vid: ld_vid, members: ld_members};
            end else if (strip_go) begin
                tbl[i].members <= tbl[i].members & strip_keep;
            end
        end
    end

    // lowest index wins: scan downward so later assignments override
    always_comb begin
        q_match = 1'b0; q_match_idx = '0;
        q_free  = 1'b0; q_free_idx  = '0;
        lk_hit  = 1'b0; lk_members  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (tbl[i].valid && tbl[i].vid == q_vid) begin
                q_match = 1'b1; q_match_idx = IDX_W'(i);
            end
            if (!tbl[i].valid) begin
                q_free = 1'b1; q_free_idx = IDX_W'(i);
            end
            if (tbl[i].valid && tbl[i].vid == lk_vid) begin
                lk_hit = 1'b1; lk_members = tbl[i].members;
            end
        end
    end
endmodule

// File: rtl/vtab_seq.sv
module vtab_seq
    import vtab_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  vcmd_t            cmd,
    input  logic             q_match,
    input  logic [IDX_W-1:0] q_match_idx,
    input  logic             q_free,
    input  logic [IDX_W-1:0] q_free_idx,
    output logic             ld_go,
    output logic [IDX_W-1:0] ld_idx,
    output logic             inv_go,
    output logic [IDX_W-1:0] inv_idx,
    output logic             strip_go,
    output logic [MEM_W-1:0] strip_keep,
    output logic             op_done,
    output logic             set_full
);
    logic [IDX_W-1:0] flush_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            flush_cnt <= '0;
        else if (busy && cmd.op == OP_FLUSH)
            flush_cnt <= (flush_cnt == IDX_W'(ENTRIES - 1)) ? '0 : flush_cnt + 1'b1;
    end

    always_comb begin
        ld_go      = 1'b0;
        ld_idx     = q_match ? q_match_idx : q_free_idx;
        inv_go     = 1'b0;
        inv_idx    = q_match_idx;
        strip_go   = 1'b0;
        strip_keep = keep_mask(cmd.port);
        op_done    = busy;
        set_full   = 1'b0;
        if (busy) begin
            case (cmd.op)
                OP_LOAD: begin
                    ld_go    = q_match || q_free;
                    set_full = !(q_match || q_free);
                end
                OP_PURGE: inv_go = q_match;
                OP_STRIP: strip_go = 1'b1;
                OP_FLUSH: begin
                    inv_go  = 1'b1;
                    inv_idx = flush_cnt;
                    op_done = (flush_cnt == IDX_W'(ENTRIES - 1));
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vtab_engine.sv
module vtab_engine
    import vtab_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       cmd_rdata,
    output logic [31:0]       data_rdata,
    input  logic [11:0]       lk_vid,
    output logic              lk_hit,
    output logic [9:0]        lk_members
);
    localparam int IDX_W = $clog2(ENTRIES);

    vcmd_t            cmd;
    logic             busy, full, dvalid, op_done, set_full;
    logic [MEM_W-1:0] dmembers, strip_keep;
    logic             q_match, q_free, ld_go, inv_go, strip_go;
    logic [IDX_W-1:0] q_match_idx, q_free_idx, ld_idx, inv_idx;

    vtab_regs u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .op_done(op_done), .set_full(set_full),
        .cmd(cmd), .busy(busy), .full(full),
        .dmembers(dmembers), .dvalid(dvalid)
    );

    vtab_seq #(.ENTRIES(ENTRIES)) u_seq (
        .clk(clk), .rst(rst), .busy(busy), .cmd(cmd),
        .q_match(q_match), .q_match_idx(q_match_idx),
        .q_free(q_free), .q_free_idx(q_free_idx),
        .ld_go(ld_go), .ld_idx(ld_idx), .inv_go(inv_go), .inv_idx(inv_idx),
        .strip_go(strip_go), .strip_keep(strip_keep),
        .op_done(op_done), .set_full(set_full)
    );

    vtab_store #(.ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst(rst),
        .ld_go(ld_go), .ld_idx(ld_idx), .ld_vid(cmd.vid), .ld_members(dmembers),
        .inv_go(inv_go), .inv_idx(inv_idx),
        .strip_go(strip_go), .strip_keep(strip_keep),
        .q_vid(cmd.vid), .q_match(q_match), .q_match_idx(q_match_idx),
        .q_free(q_free), .q_free_idx(q_free_idx),
        .lk_vid(lk_vid), .lk_hit(lk_hit), .lk_members(lk_members)
    );

    assign cmd_rdata  = {cmd.prio_en, cmd.prio, cmd.vid, 4'b0, cmd.port,
                         3'b0, full, busy, cmd.op};
    assign data_rdata = {20'b0, dvalid, 1'b0, dmembers};
endmodule

// File: rtl/vtab_engine_chk.sv
module vtab_engine_chk #(
    parameter int ENTRIES = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [31:0] cmd_rdata,
    input logic [31:0] data_rdata,
    input logic        lk_hit
);
    logic       act;
    logic [2:0] op;
    logic [31:0] flush_run;
    assign act = cmd_rdata[3];
    assign op  = cmd_rdata[2:0];

    always_ff @(posedge clk) begin
        if (rst) flush_run <= '0;
        else if (act && op == 3'd1) flush_run <= flush_run + 1;
        else flush_run <= '0;
    end

    // R8: a flush never stays busy longer than the table depth
    always_ff @(posedge clk)
        if (!rst) p_flush_bound_r8: assert (flush_run <= 32'(ENTRIES));

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cmd_rdata == 32'h0 && data_rdata == 32'h0));

    p_single_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        (act && op != 3'd1) |=> !act);

    p_busy_holds_cmd_r9: assert property (@(posedge clk) disable iff (rst)
        act |=> ($stable(cmd_rdata[31:8]) && $stable(cmd_rdata[2:0])));

    p_busy_holds_data_r9: assert property (@(posedge clk) disable iff (rst)
        (act && reg_wr) |=> $stable(data_rdata));

    p_full_from_load_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_rdata[4]) |-> (op == 3'd2 && !act));

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(act) && op == 3'd1) |-> !lk_hit);
endmodule

bind vtab_engine vtab_engine_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .cmd_rdata(cmd_rdata),
    .data_rdata(data_rdata), .lk_hit(lk_hit)
);

// File: tb/vtab_engine_tb.sv
`timescale 1ns/1ps
module vtab_engine_tb;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] cmd_rdata, data_rdata;
    logic [11:0] lk_vid = '0;
    logic        lk_hit;
    logic [9:0]  lk_members;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    vtab_engine u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cmd_rdata(cmd_rdata), .data_rdata(data_rdata),
        .lk_vid(lk_vid), .lk_hit(lk_hit), .lk_members(lk_members)
    );

    // reference model
    bit        m_val [N];
    bit [11:0] m_vid [N];
    bit [9:0]  m_mem [N];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [31:0] val);
        @(negedge clk);
        reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [31:0] cmdw(input [2:0] op, input bit go, input [11:0] vid, input [3:0] port);
        return {1'b0, 3'd0, vid, 4'd0, port, 3'd0, 1'b0, go, op};
    endfunction

    task automatic go(input [2:0] op, input [11:0] vid, input [3:0] port, output int cyc);
        wr(1'b0, cmdw(op, 1'b1, vid, port));
        cyc = 0;
        while (cmd_rdata[3] && cyc < 100) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic lookup(input [11:0] v, output bit h, output bit [9:0] m);
        lk_vid = v;
        #0.5;
        h = lk_hit; m = lk_members;
    endtask

    // model ops; returns 1 if a load would find the table full
    function automatic bit m_load(input [11:0] v, input [9:0] mem);
        for (int i = 0; i < N; i++)
            if (m_val[i] && m_vid[i] == v) begin m_mem[i] = mem; return 0; end
        for (int i = 0; i < N; i++)
            if (!m_val[i]) begin m_val[i] = 1; m_vid[i] = v; m_mem[i] = mem; return 0; end
        return 1;
    endfunction

    task automatic check_table(input string req);
        bit h; bit [9:0] m;
        for (int i = 0; i < N; i++) begin
            if (m_val[i]) begin
                lookup(m_vid[i], h, m);
                check(h && m == m_mem[i], req, {h, m}, {1'b1, m_mem[i]});
            end
        end
        lookup(12'd4000, h, m);
        check(!h && m == 0, req, {h, m}, 0);
    endtask

    task automatic do_load(input [11:0] v, input [9:0] mem, input string req);
        int cyc; bit efull;
        wr(1'b1, {20'd0, 1'b0, 1'b0, mem});   // valid bit left clear on purpose
        efull = m_load(v, mem);
        go(3'd2, v, 4'd0, cyc);
        check(cyc == 1, "R2 load busy length", cyc, 1);
        check(cmd_rdata[4] == efull, req, cmd_rdata[4], efull);
    endtask

    initial begin : main
        int cyc; bit h; bit [9:0] m; bit [11:0] v;
        for (int i = 0; i < N; i++) begin m_val[i] = 0; m_vid[i] = 0; m_mem[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(cmd_rdata == 0, "R1 cmd after reset", cmd_rdata, 0);
        check(data_rdata == 0, "R1 data after reset", data_rdata, 0);
        for (int k = 0; k < 8; k++) begin
            lookup(12'(k * 517), h, m);
            check(!h, "R1 lookup miss after reset", h, 0);
        end

        // R10 field readback, bit 4 not writable, no start without bit 3
        wr(1'b0, 32'hEABC_F5F4);
        check(cmd_rdata == 32'hEABC_0504, "R10 cmd readback", cmd_rdata, 32'hEABC_0504);
        wr(1'b1, 32'hFFFF_FFFF);
        check(data_rdata == 32'h0000_0BFF, "R10 data readback", data_rdata, 32'h0000_0BFF);

        // R11 no-op and codes 5..7
        for (int c = 0; c < 8; c++) begin
            if (c >= 1 && c <= 4) continue;
            go(3'(c), 12'd7, 4'd1, cyc);
            check(cyc == 1, "R11 inert op busy length", cyc, 1);
        end
        check_table("R11 table unchanged by inert op");

        // R3 / R5 fill the table
        for (int i = 0; i < N; i++) begin
            do_load(12'(100 + i * 7), 10'((i * 37 + 5) & 10'h3FF), "R3 load no full");
        end
        check_table("R3 lookup after fill");

        // R4 overwrite in place
        do_load(12'(100 + 3 * 7), 10'h2AA, "R4 overwrite no full");
        check_table("R4 overwrite lookup");

        // R5 full table rejects new VID
        do_load(12'd777, 10'h155, "R5 full flag raised");
        lookup(12'd777, h, m);
        check(!h, "R5 rejected load absent", h, 0);
        check_table("R5 table unchanged on full");
        go(3'd0, 12'd0, 4'd0, cyc);
        check(cmd_rdata[4] == 0, "R5 full cleared by new cmd", cmd_rdata[4], 0);

        // R6 purge one entry, free slot reused
        v = 12'(100 + 5 * 7);
        go(3'd3, v, 4'd0, cyc);
        check(cyc == 1, "R2 purge busy length", cyc, 1);
        m_val[5] = 0;
        lookup(v, h, m);
        check(!h, "R6 purged VID misses", h, 0);
        check_table("R6 others intact");
        go(3'd3, 12'd3333, 4'd0, cyc);
        check_table("R6 purge of absent VID");
        do_load(12'd999, 10'h0F0, "R5 freed slot reused");
        do_load(12'd998, 10'h00F, "R5 full after reuse");
        check_table("R5 after reuse");

        // R7 remove port
        go(3'd4, 12'd0, 4'd3, cyc);
        check(cyc == 1, "R2 strip busy length", cyc, 1);
        for (int i = 0; i < N; i++) m_mem[i] &= ~10'h008;
        check_table("R7 port 3 stripped");
        go(3'd4, 12'd0, 4'd9, cyc);
        for (int i = 0; i < N; i++) m_mem[i] &= ~10'h200;
        check_table("R7 port 9 stripped");
        go(3'd4, 12'd0, 4'd12, cyc);
        check_table("R7 port 12 no effect");

        // R8 flush
        go(3'd1, 12'd0, 4'd0, cyc);
        check(cyc == N, "R8 flush busy length", cyc, N);
        for (int i = 0; i < N; i++) m_val[i] = 0;
        check_table("R8 empty after flush");
        for (int i = 0; i < N; i++) begin
            lookup(12'(100 + i * 7), h, m);
            check(!h, "R8 flushed VID misses", h, 0);
        end

        // R9 writes during busy are ignored
        do_load(12'd50, 10'h011, "R3 reload after flush");
        do_load(12'd51, 10'h022, "R3 reload after flush");
        wr(1'b0, cmdw(3'd1, 1'b1, 12'd0, 4'd0));
        wr(1'b1, 32'h0000_0BFF);
        wr(1'b0, cmdw(3'd2, 1'b1, 12'd60, 4'd7));
        check(cmd_rdata == 32'h0000_0009, "R9 cmd unchanged while busy", cmd_rdata, 32'h9);
        check(data_rdata == 32'h0000_0022, "R9 data unchanged while busy", data_rdata, 32'h22);
        cyc = 0;
        while (cmd_rdata[3] && cyc < 100) begin cyc++; @(negedge clk); end
        for (int i = 0; i < N; i++) m_val[i] = 0;
        lookup(12'd60, h, m);
        check(!h, "R9 ignored load not applied", h, 0);
        check_table("R9 flush completed");
        check(cmd_rdata[2:0] == 3'd1, "R9 op field kept", cmd_rdata[2:0], 1);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule